// File: doc/BRIEF.md
# Packed Floating-Point Round-to-Integral Unit

This unit takes a 256-bit vector operand and replaces every floating-point lane with an integral value, and keeps that value in floating-point form. A format input chooses how the vector is split: eight 32-bit single-precision lanes or four 64-bit double-precision lanes. A 3-bit mode input chooses the rounding direction. It can name one of four fixed directions, or it can tell the unit to use the 2-bit rounding field that the surrounding core keeps in its floating-point control register.

The unit is a pipeline with a fixed latency of four cycles. It can accept a new operand on every clock. Each result leaves the unit with a valid strobe and two summary exception flags: inexact and invalid. Each flag is the OR of the matching flag across all lanes of that operand.

Top module: `vfp_round_int`

## Requirements
- R1: With `in_fmt`=0, lane i (i = 0..7) is bits [32i+31:32i] and is processed as binary32. With `in_fmt`=1, lane j (j = 0..3) is bits [64j+63:64j] and is processed as binary64. Every result lane sits in the same bit positions as its input lane.
- R2: When `in_mode`[2]=0, the direction is `in_mode`[1:0] and `dyn_rm` is ignored. When `in_mode`[2]=1, the direction is `dyn_rm` and `in_mode`[1:0] is ignored. Both fields use the same direction encoding: 0 = nearest with ties to even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity.
- R3: In nearest-even mode, a lane goes to the nearest integer. An exact tie goes to the even neighbour: ±0.5→±0, ±1.5→±2, ±2.5→±2, and 2^23−0.5→2^23.
- R4: Toward-zero mode truncates the magnitude. Toward +infinity gives the smallest integer not below the input. Toward −infinity gives the largest integer not above the input.
- R5: When `in_valid` is high at clock edge k, the result and `out_valid` appear after edge k+4. Back-to-back operands each produce a result. A cycle with `in_valid` low produces a cycle with `out_valid` low.
- R6: Some lanes are already integral and come out bit-identical with no flag raised. These are finite lanes with a biased exponent of at least bias+23 (single) or bias+52 (double), infinities, and zeros of either sign.
- R7: A quiet NaN comes out unchanged with no flag. A signaling NaN (mantissa MSB = 0, payload nonzero) comes out with the mantissa MSB set and the rest of its bits kept, and it raises the invalid flag.
- R8: Every non-NaN result keeps the input's sign. A negative input that rounds to zero gives −0.0.
- R9: A lane's inexact flag is set exactly when its result differs from its input (NaNs excluded). `out_inexact` and `out_invalid` are the OR over all lanes and are low whenever `out_valid` is low.
- R10: During reset and in the first cycle after it, `out_valid`, `out_data` and both flags are zero. A reset also discards any operands still in the pipeline.
- R11: A subnormal input counts as a nonzero value below one. It rounds to ±0 or ±1 according to the direction and raises inexact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_fmt | input | 1 | 0 = eight binary32 lanes, 1 = four binary64 lanes |
| in_mode | input | 3 | Bit 2 selects dynamic; bits 1:0 give the static direction |
| dyn_rm | input | 2 | Rounding direction from the control register |
| in_data | input | VEC_W | Packed operand |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | VEC_W | Packed rounded result |
| out_inexact | output | 1 | OR of per-lane inexact flags |
| out_invalid | output | 1 | OR of per-lane invalid flags |

## Verification
The bench builds the unit with the default vector width of 256 bits. That gives eight single lanes and four double lanes, so each case can be placed in every lane slot. The same bits can also be checked under both splittings to show that the format select changes the result. With both binary formats present, the 2^23 and 2^52 integral thresholds are reached, and so are carries from the all-ones mantissa into the next exponent, subnormal and maximum-finite operands, and signaling-NaN quieting at both widths. Double-precision expectations come from a real-number model in the bench. Single-precision expectations come from a hand-derived vector table.

// File: rtl/fr_pkg.sv
package fr_pkg;

    localparam int VEC_W_DEF = 256;

    // binary32 lane geometry
    localparam int SP_W     = 32;
    localparam int SP_EXP_W = 8;
    localparam int SP_MAN_W = 23;

    // binary64 lane geometry
    localparam int DP_W     = 64;
    localparam int DP_EXP_W = 11;
    localparam int DP_MAN_W = 52;

    // rounding direction; encoding shared by static and dynamic select
    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'd0,
        RM_TO_ZERO   = 2'd1,
        RM_UP        = 2'd2,
        RM_DOWN      = 2'd3
    } rnd_dir_e;

    typedef enum logic {
        FMT_SP = 1'b0,
        FMT_DP = 1'b1
    } lane_fmt_e;

    typedef struct packed {
        logic      valid;
        lane_fmt_e fmt;
        rnd_dir_e  dir;
    } op_ctl_t;

    // bit 2 of the mode field hands the choice to the control register
    function automatic rnd_dir_e pick_dir(input logic [2:0] mode_sel,
                                          input logic [1:0] dyn);
        return mode_sel[2] ? rnd_dir_e'(dyn) : rnd_dir_e'(mode_sel[1:0]);
    endfunction

endpackage

// File: rtl/fr_lane.sv
module fr_lane
    import fr_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] op_i,
    input  rnd_dir_e     dir_i,
    output logic [W-1:0] res_o,
    output logic         inexact_o,
    output logic         invalid_o
);

    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam int SIG_W = MAN_W + 2;
    localparam logic [EXP_W-1:0] EX_ONE   = EXP_W'(BIAS);
    localparam logic [EXP_W-1:0] EX_HALF  = EXP_W'(BIAS - 1);
    localparam logic [EXP_W-1:0] EX_INTEG = EXP_W'(BIAS + MAN_W);
    localparam logic [SIG_W-1:0] SIG_ONE  = SIG_W'(1);

    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] man;
    assign {sgn, ex, man} = op_i;

    logic is_special, is_nan, is_zero;
    assign is_special = &ex;
    assign is_nan     = is_special && (man != '0);
    assign is_zero    = (ex == '0) && (man == '0);

    // fractional path: 1 <= |x| < 2^MAN_W
    logic [EXP_W-1:0] frac_cnt;
    logic [EXP_W-1:0] bumped_ex;
    logic [SIG_W-1:0] sig, unit, mask, half, low, trunc, sum;
    logic             odd, bump;

    always_comb begin
        frac_cnt  = EX_INTEG - ex;
        bumped_ex = ex + EXP_W'(1);
        sig       = {2'b01, man};
        unit      = SIG_ONE << frac_cnt;
        mask      = unit - SIG_ONE;
        half      = unit >> 1;
        low       = sig & mask;
        trunc     = sig & ~mask;
        odd       = |(sig & unit);
        case (dir_i)
            RM_NEAR_EVEN: bump = (low > half) || ((low == half) && odd);
            RM_TO_ZERO:   bump = 1'b0;
            RM_UP:        bump = !sgn && (low != '0);
            default:      bump = sgn && (low != '0);
        endcase
        sum = trunc + (bump ? unit : '0);
    end

    // tiny path: 0 < |x| < 1, result is 0 or 1 in magnitude
    logic             tiny_up;
    logic [EXP_W-1:0] tiny_ex;

    always_comb begin
        case (dir_i)
            RM_NEAR_EVEN: tiny_up = (ex == EX_HALF) && (man != '0);
            RM_TO_ZERO:   tiny_up = 1'b0;
            RM_UP:        tiny_up = !sgn;
            default:      tiny_up = sgn;
        endcase
        tiny_ex = tiny_up ? EX_ONE : '0;
    end

    always_comb begin
        res_o     = op_i;
        inexact_o = 1'b0;
        invalid_o = 1'b0;
        if (is_special) begin
            if (is_nan) begin
                res_o[MAN_W-1] = 1'b1;
                invalid_o      = !man[MAN_W-1];
            end
        end else if ((ex >= EX_INTEG) || is_zero) begin
            res_o = op_i;
        end else if (ex < EX_ONE) begin
            inexact_o = 1'b1;
            res_o     = {sgn, tiny_ex, {MAN_W{1'b0}}};
        end else begin
            inexact_o = (low != '0);
            if (sum[SIG_W-1]) begin
                res_o = {sgn, bumped_ex, {MAN_W{1'b0}}};
            end else begin
                res_o = {sgn, ex, sum[MAN_W-1:0]};
            end
        end
    end

    always_comb begin
        if (!is_special && (ex >= EX_INTEG)) begin
            // R6
            pass_integral_chk: assert (res_o == op_i && !inexact_o);
        end
        if (!is_nan) begin
            // R8
            sign_keep_chk: assert (res_o[W-1] == op_i[W-1]);
            // R9
            exact_flag_chk: assert (inexact_o == (res_o != op_i));
        end
        if (invalid_o) begin
            // R7
            invalid_src_chk: assert (is_nan && !man[MAN_W-1]);
        end
        if (!is_special && (ex >= EX_ONE) && (ex < EX_INTEG) && !sum[SIG_W-1]) begin
            // R4
            norm_keep_chk: assert (sum[MAN_W]);
        end
    end

endmodule

// File: rtl/fr_lane_array.sv
module fr_lane_array
    import fr_pkg::*;
#(
    parameter int VEC_W  = VEC_W_DEF,
    localparam int SP_N  = VEC_W / SP_W,
    localparam int DP_N  = VEC_W / DP_W
) (
    input  lane_fmt_e        fmt_i,
    input  rnd_dir_e         dir_i,
    input  logic [VEC_W-1:0] vec_i,
    output logic [VEC_W-1:0] vec_o,
    output logic [SP_N-1:0]  ix_o,
    output logic [SP_N-1:0]  iv_o
);

    logic [VEC_W-1:0] sp_res, dp_res;
    logic [SP_N-1:0]  sp_ix, sp_iv, dp_ix, dp_iv;

    for (genvar g = 0; g < SP_N; g++) begin : g_sp
        fr_lane #(
            .EXP_W (SP_EXP_W),
            .MAN_W (SP_MAN_W)
        ) u_sp (
            .op_i      (vec_i[g*SP_W +: SP_W]),
            .dir_i     (dir_i),
            .res_o     (sp_res[g*SP_W +: SP_W]),
            .inexact_o (sp_ix[g]),
            .invalid_o (sp_iv[g])
        );
    end

    // each double lane reports on the even slot of its single-lane pair
    for (genvar g = 0; g < DP_N; g++) begin : g_dp
        fr_lane #(
            .EXP_W (DP_EXP_W),
            .MAN_W (DP_MAN_W)
        ) u_dp (
            .op_i      (vec_i[g*DP_W +: DP_W]),
            .dir_i     (dir_i),
            .res_o     (dp_res[g*DP_W +: DP_W]),
            .inexact_o (dp_ix[2*g]),
            .invalid_o (dp_iv[2*g])
        );
        assign dp_ix[2*g+1] = 1'b0;
        assign dp_iv[2*g+1] = 1'b0;
    end

    assign vec_o = (fmt_i == FMT_DP) ? dp_res : sp_res;
    assign ix_o  = (fmt_i == FMT_DP) ? dp_ix  : sp_ix;
    assign iv_o  = (fmt_i == FMT_DP) ? dp_iv  : sp_iv;

endmodule

// File: rtl/vfp_round_int.sv
module vfp_round_int
    import fr_pkg::*;
#(
    parameter int VEC_W = VEC_W_DEF,
    localparam int SP_N = VEC_W / SP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_fmt,
    input  logic [2:0]       in_mode,
    input  logic [1:0]       dyn_rm,
    input  logic [VEC_W-1:0] in_data,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_data,
    output logic             out_inexact,
    output logic             out_invalid
);

    localparam int STAGES = 4;
    localparam int WARM_W = $clog2(STAGES + 1);

    // stage 1: capture operand, resolve direction
    op_ctl_t          s1_ctl;
    logic [VEC_W-1:0] s1_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_ctl  <= '0;
            s1_data <= '0;
        end else begin
            s1_ctl.valid <= in_valid;
            if (in_valid) begin
                s1_ctl.fmt <= lane_fmt_e'(in_fmt);
                s1_ctl.dir <= pick_dir(in_mode, dyn_rm);
                s1_data    <= in_data;
            end
        end
    end

    logic [VEC_W-1:0] lane_res;
    logic [SP_N-1:0]  lane_ix, lane_iv;

    fr_lane_array #(
        .VEC_W (VEC_W)
    ) u_lanes (
        .fmt_i (s1_ctl.fmt),
        .dir_i (s1_ctl.dir),
        .vec_i (s1_data),
        .vec_o (lane_res),
        .ix_o  (lane_ix),
        .iv_o  (lane_iv)
    );

    // stage 2: per-lane results and flags
    logic             s2_valid;
    logic [VEC_W-1:0] s2_data;
    logic [SP_N-1:0]  s2_ix, s2_iv;

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid <= 1'b0;
            s2_data  <= '0;
            s2_ix    <= '0;
            s2_iv    <= '0;
        end else begin
            s2_valid <= s1_ctl.valid;
            s2_ix    <= s1_ctl.valid ? lane_ix : '0;
            s2_iv    <= s1_ctl.valid ? lane_iv : '0;
            if (s1_ctl.valid) begin
                s2_data <= lane_res;
            end
        end
    end

    // stage 3: flag reduction
    logic             s3_valid, s3_ix, s3_iv;
    logic [VEC_W-1:0] s3_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            s3_valid <= 1'b0;
            s3_data  <= '0;
            s3_ix    <= 1'b0;
            s3_iv    <= 1'b0;
        end else begin
            s3_valid <= s2_valid;
            s3_ix    <= |s2_ix;
            s3_iv    <= |s2_iv;
            if (s2_valid) begin
                s3_data <= s2_data;
            end
        end
    end

    // stage 4: output register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_inexact <= 1'b0;
            out_invalid <= 1'b0;
        end else begin
            out_valid   <= s3_valid;
            out_inexact <= s3_valid & s3_ix;
            out_invalid <= s3_valid & s3_iv;
            if (s3_valid) begin
                out_data <= s3_data;
            end
        end
    end

    // edges since reset, saturating at pipeline depth
    logic [WARM_W-1:0] warm;
    always_ff @(posedge clk) begin
        if (rst) begin
            warm <= '0;
        end else if (warm != WARM_W'(STAGES)) begin
            warm <= warm + WARM_W'(1);
        end
    end

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (warm == WARM_W'(STAGES)) |-> (out_valid == $past(in_valid, STAGES)));

    // R9
    flag_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_inexact && !out_invalid));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_data == '0 && !out_inexact && !out_invalid));

endmodule

// File: tb/tb_vfp_round_int.sv
`timescale 1ns/1ps
module tb_vfp_round_int;

    localparam int VW   = 256;
    localparam int LAT  = 4;
    localparam int MAXQ = 96;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_fmt = 1'b0;
    logic [2:0]    in_mode = '0;
    logic [1:0]    dyn_rm = '0;
    logic [VW-1:0] in_data = '0;
    logic          out_valid;
    logic [VW-1:0] out_data;
    logic          out_inexact, out_invalid;

    always #2 clk = ~clk;

    vfp_round_int #(.VEC_W(VW)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_fmt(in_fmt),
        .in_mode(in_mode), .dyn_rm(dyn_rm), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data),
        .out_inexact(out_inexact), .out_invalid(out_invalid)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    function automatic string req_name(input int r);
        case (r)
            1:  return "R1";
            2:  return "R2";
            3:  return "R3";
            4:  return "R4";
            5:  return "R5";
            6:  return "R6";
            7:  return "R7";
            8:  return "R8";
            9:  return "R9";
            10: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input bit ok, input int req, input string what,
                       input logic [VW-1:0] act, input logic [VW-1:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req_name(req), what, act, expv);
        end
    endtask

    // single-precision vectors: mode, dyn, input, result, inexact, invalid, requirement
    typedef struct packed {
        logic [2:0]  mode;
        logic [1:0]  dyn;
        logic [31:0] a;
        logic [31:0] r;
        logic        ix;
        logic        iv;
        logic [3:0]  req;
    } sp_case_t;

    localparam int NSP = 41;
    localparam sp_case_t SP_TAB [NSP] = '{
        // R3 nearest-even, R8 negative to -0
        '{3'd0, 2'd0, 32'h3F000000, 32'h00000000, 1'b1, 1'b0, 4'd3},
        '{3'd0, 2'd0, 32'hBF000000, 32'h80000000, 1'b1, 1'b0, 4'd8},
        '{3'd0, 2'd0, 32'h3FC00000, 32'h40000000, 1'b1, 1'b0, 4'd3},
        '{3'd0, 2'd0, 32'h40200000, 32'h40000000, 1'b1, 1'b0, 4'd3},
        '{3'd0, 2'd0, 32'hBFC00000, 32'hC0000000, 1'b1, 1'b0, 4'd3},
        '{3'd0, 2'd0, 32'hC0200000, 32'hC0000000, 1'b1, 1'b0, 4'd3},
        '{3'd0, 2'd0, 32'h3F333333, 32'h3F800000, 1'b1, 1'b0, 4'd3},
        '{3'd0, 2'd0, 32'h3FA00000, 32'h3F800000, 1'b1, 1'b0, 4'd3},
        '{3'd0, 2'd0, 32'h4AFFFFFF, 32'h4B000000, 1'b1, 1'b0, 4'd3},
        // R4 toward zero
        '{3'd1, 2'd0, 32'h3FC00000, 32'h3F800000, 1'b1, 1'b0, 4'd4},
        '{3'd1, 2'd0, 32'hBFC00000, 32'hBF800000, 1'b1, 1'b0, 4'd4},
        '{3'd1, 2'd0, 32'hBF000000, 32'h80000000, 1'b1, 1'b0, 4'd8},
        '{3'd1, 2'd0, 32'h4AFFFFFF, 32'h4AFFFFFE, 1'b1, 1'b0, 4'd4},
        '{3'd1, 2'd0, 32'h3F333333, 32'h00000000, 1'b1, 1'b0, 4'd4},
        // R4 toward +inf, R11 subnormals
        '{3'd2, 2'd0, 32'h3FA00000, 32'h40000000, 1'b1, 1'b0, 4'd4},
        '{3'd2, 2'd0, 32'hBFA00000, 32'hBF800000, 1'b1, 1'b0, 4'd4},
        '{3'd2, 2'd0, 32'hBF000000, 32'h80000000, 1'b1, 1'b0, 4'd8},
        '{3'd2, 2'd0, 32'h00000001, 32'h3F800000, 1'b1, 1'b0, 4'd11},
        '{3'd2, 2'd0, 32'h80000001, 32'h80000000, 1'b1, 1'b0, 4'd11},
        // R4 toward -inf
        '{3'd3, 2'd0, 32'h3FA00000, 32'h3F800000, 1'b1, 1'b0, 4'd4},
        '{3'd3, 2'd0, 32'hBFA00000, 32'hC0000000, 1'b1, 1'b0, 4'd4},
        '{3'd3, 2'd0, 32'h3F000000, 32'h00000000, 1'b1, 1'b0, 4'd4},
        '{3'd3, 2'd0, 32'hBF000000, 32'hBF800000, 1'b1, 1'b0, 4'd4},
        '{3'd3, 2'd0, 32'h80000001, 32'hBF800000, 1'b1, 1'b0, 4'd11},
        // R2 dynamic select and ignored fields
        '{3'd4, 2'd0, 32'h40200000, 32'h40000000, 1'b1, 1'b0, 4'd2},
        '{3'd4, 2'd1, 32'h3FC00000, 32'h3F800000, 1'b1, 1'b0, 4'd2},
        '{3'd4, 2'd2, 32'h3FA00000, 32'h40000000, 1'b1, 1'b0, 4'd2},
        '{3'd4, 2'd3, 32'hBFA00000, 32'hC0000000, 1'b1, 1'b0, 4'd2},
        '{3'd7, 2'd2, 32'hBFC00000, 32'hBF800000, 1'b1, 1'b0, 4'd2},
        '{3'd0, 2'd3, 32'h3FC00000, 32'h40000000, 1'b1, 1'b0, 4'd2},
        // R6 pass-through, R7 NaN, R9 exact below threshold
        '{3'd2, 2'd0, 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 1'b0, 4'd6},
        '{3'd2, 2'd0, 32'h4B000001, 32'h4B000001, 1'b0, 1'b0, 4'd6},
        '{3'd2, 2'd0, 32'h4B000000, 32'h4B000000, 1'b0, 1'b0, 4'd6},
        '{3'd2, 2'd0, 32'h7F800000, 32'h7F800000, 1'b0, 1'b0, 4'd6},
        '{3'd3, 2'd0, 32'hFF800000, 32'hFF800000, 1'b0, 1'b0, 4'd6},
        '{3'd2, 2'd0, 32'h80000000, 32'h80000000, 1'b0, 1'b0, 4'd6},
        '{3'd3, 2'd0, 32'h00000000, 32'h00000000, 1'b0, 1'b0, 4'd6},
        '{3'd2, 2'd0, 32'h7FC00000, 32'h7FC00000, 1'b0, 1'b0, 4'd7},
        '{3'd2, 2'd0, 32'h7F800001, 32'h7FC00001, 1'b0, 1'b1, 4'd7},
        '{3'd0, 2'd0, 32'hFFBFFFFF, 32'hFFFFFFFF, 1'b0, 1'b1, 4'd7},
        '{3'd2, 2'd0, 32'h4AFFFFFE, 32'h4AFFFFFE, 1'b0, 1'b0, 4'd9}
    };

    // double-precision reference model on real numbers
    function automatic logic [63:0] dref(input logic [63:0] a, input logic [1:0] d,
                                         output logic ix, output logic iv);
        real r, fl, cl, q, diff;
        logic [63:0] b;
        ix = 1'b0;
        iv = 1'b0;
        if (a[62:52] == 11'h7FF) begin
            if (a[51:0] != '0) begin
                iv = !a[51];
                return a | (64'h1 << 51);
            end
            return a;
        end
        r  = $bitstoreal(a);
        fl = $floor(r);
        cl = $ceil(r);
        case (d)
            2'd0: begin
                diff = r - fl;
                if (diff > 0.5)      q = fl + 1.0;
                else if (diff < 0.5) q = fl;
                else                 q = ((fl - 2.0 * $floor(fl / 2.0)) == 0.0) ? fl : fl + 1.0;
            end
            2'd1:    q = (r < 0.0) ? cl : fl;
            2'd2:    q = cl;
            default: q = fl;
        endcase
        b = $realtobits(q);
        if (q == 0.0) b = {a[63], 63'b0};
        ix = (b != a);
        return b;
    endfunction

    // operation queue
    logic          q_v    [MAXQ];
    logic          q_fmt  [MAXQ];
    logic [2:0]    q_mode [MAXQ];
    logic [1:0]    q_dyn  [MAXQ];
    logic [VW-1:0] q_data [MAXQ];
    logic [VW-1:0] q_exp  [MAXQ];
    logic          q_ix   [MAXQ];
    logic          q_iv   [MAXQ];
    int            q_req  [MAXQ];
    int            n_ops = 0;

    task automatic add_op(input bit v, input bit fmt, input logic [2:0] mode,
                          input logic [1:0] dyn, input logic [VW-1:0] d,
                          input logic [VW-1:0] e, input bit ix, input bit iv, input int req);
        q_v[n_ops]    = v;
        q_fmt[n_ops]  = fmt;
        q_mode[n_ops] = mode;
        q_dyn[n_ops]  = dyn;
        q_data[n_ops] = d;
        q_exp[n_ops]  = e;
        q_ix[n_ops]   = ix;
        q_iv[n_ops]   = iv;
        q_req[n_ops]  = req;
        n_ops++;
    endtask

    task automatic check_slot(input int k);
        if (q_v[k]) begin
            chk(out_valid == 1'b1, 5, "valid after four edges", VW'(out_valid), VW'(1));
            chk(out_data == q_exp[k], q_req[k], "result vector", out_data, q_exp[k]);
            chk(out_inexact == q_ix[k], q_req[k], "inexact flag", VW'(out_inexact), VW'(q_ix[k]));
            chk(out_invalid == q_iv[k], q_req[k], "invalid flag", VW'(out_invalid), VW'(q_iv[k]));
        end else begin
            chk(out_valid == 1'b0, 5, "bubble gives no valid", VW'(out_valid), VW'(0));
            chk(!out_inexact && !out_invalid, 9, "flags low while idle",
                VW'({out_inexact, out_invalid}), VW'(0));
        end
    endtask

    task automatic run_stream();
        for (int cyc = 0; cyc < n_ops + LAT; cyc++) begin
            @(negedge clk);
            if (cyc >= LAT) check_slot(cyc - LAT);
            if (cyc < n_ops) begin
                in_valid = q_v[cyc];
                in_fmt   = q_fmt[cyc];
                in_mode  = q_mode[cyc];
                dyn_rm   = q_dyn[cyc];
                in_data  = q_data[cyc];
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] dv [12];

        // R10 reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, 10, "valid in reset", VW'(out_valid), VW'(0));
        chk(out_data == '0, 10, "data in reset", out_data, '0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && !out_inexact && !out_invalid, 10, "idle after reset",
            VW'({out_valid, out_inexact, out_invalid}), VW'(0));

        // single-precision table, case k in lane k%8, other lanes hold exact 1.0
        for (int k = 0; k < NSP; k++) begin
            logic [VW-1:0] d, e;
            for (int l = 0; l < 8; l++) begin
                d[l*32 +: 32] = 32'h3F800000;
                e[l*32 +: 32] = 32'h3F800000;
            end
            d[(k % 8)*32 +: 32] = SP_TAB[k].a;
            e[(k % 8)*32 +: 32] = SP_TAB[k].r;
            add_op(1'b1, 1'b0, SP_TAB[k].mode, SP_TAB[k].dyn, d, e,
                   SP_TAB[k].ix, SP_TAB[k].iv, int'(SP_TAB[k].req));
            if (k == 9) add_op(1'b0, 1'b0, 3'd0, 2'd0, '0, '0, 1'b0, 1'b0, 5);
        end

        // double-precision lanes against the real-number model
        dv[0]  = $realtobits(0.5);
        dv[1]  = $realtobits(-1.5);
        dv[2]  = $realtobits(2.5);
        dv[3]  = $realtobits(-2.5);
        dv[4]  = $realtobits(3.7);
        dv[5]  = $realtobits(-0.3);
        dv[6]  = $realtobits(4503599627370496.0 - 0.5);
        dv[7]  = $realtobits(-1.0e300);
        dv[8]  = 64'h7FEFFFFFFFFFFFFF;
        dv[9]  = 64'h0000000000000001;
        dv[10] = 64'h8000000000000001;
        dv[11] = 64'h7FF0000000000001;
        for (int m = 0; m < 5; m++) begin
            for (int g = 0; g < 3; g++) begin
                logic [VW-1:0] d, e;
                logic ixa, iva, lix, liv;
                logic [1:0] dir;
                ixa = 1'b0;
                iva = 1'b0;
                dir = (m == 4) ? 2'd3 : 2'(m);
                for (int j = 0; j < 4; j++) begin
                    d[j*64 +: 64] = dv[g*4 + j];
                    e[j*64 +: 64] = dref(dv[g*4 + j], dir, lix, liv);
                    ixa |= lix;
                    iva |= liv;
                end
                // R3 for nearest-even, R4 for directed, R2 for dynamic pass
                add_op(1'b1, 1'b1, (m == 4) ? 3'd5 : 3'(m), dir, d, e, ixa, iva,
                       (m == 4) ? 2 : ((m == 0) ? 3 : 4));
            end
        end

        // R1 same bits under both lane splittings
        begin
            logic [VW-1:0] d, e;
            logic ixa, iva, lix, liv;
            d = {8{32'h3FC00000}};
            add_op(1'b1, 1'b0, 3'd0, 2'd0, d, {8{32'h40000000}}, 1'b1, 1'b0, 1);
            ixa = 1'b0;
            iva = 1'b0;
            for (int j = 0; j < 4; j++) begin
                e[j*64 +: 64] = dref(d[j*64 +: 64], 2'd0, lix, liv);
                ixa |= lix;
                iva |= liv;
            end
            add_op(1'b1, 1'b1, 3'd0, 2'd0, d, e, ixa, iva, 1);
        end

        run_stream();

        // R10 reset discards operands in flight
        @(negedge clk);
        in_valid = 1'b1;
        in_fmt   = 1'b0;
        in_mode  = 3'd0;
        in_data  = {8{32'h3FC00000}};
        @(negedge clk);
        in_valid = 1'b0;
        rst      = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, 10, "flushed operand stays hidden", VW'(out_valid), VW'(0));
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule